// File: doc/BRIEF.md
# Packed-Lane Rounding Shift-Accumulate Unit

This unit is a one-stage SIMD datapath. It treats each operand vector as a packed row of 8-bit two's-complement lanes. In every lane it arithmetically shifts the source lane right by an immediate amount, rounding to nearest, and adds that term to the matching accumulator lane. The rounding adds half the weight of the discarded bits before the shift. The same operation runs on every lane at once, and no lane affects any other.

The vector width is a parameter. It is a multiple of 128 bits, so the unit has 16 to 256 lanes. A caller presents the accumulator vector, the source vector and a 4-bit shift amount together with a valid strobe. One clock later the sum vector appears on a registered output along with a registered valid. A shift amount outside the legal range raises an error flag instead. In that case the accumulator passes through untouched.

Top module: `lane_rshift_acc`

## Requirements
- R1: For a shift amount sh in 1..8, each output lane equals (acc + ((src + 2^(sh-1)) >>> sh)) mod 256. Here acc and src are the signed 8-bit values of that lane, lane k occupies bits [8k+7:8k], and >>> is an arithmetic right shift.
- R2: The shifted term equals the plain arithmetic shift src >>> sh, plus one when source bit sh-1 (the most significant bit discarded) is 1.
- R3: The rounding add cannot overflow before the shift. A source of +127 with sh=1 gives a term of +64, and with sh=7 it gives +1.
- R4: A shift of 8 is legal and gives a shifted term of 0 for every source value, including -128 and -1. The output lane then equals the accumulator lane.
- R5: The final addition wraps modulo 256 in each lane. There is no saturation and no overflow flag. For example, acc=127 with a term of +1 gives -128.
- R6: A shift amount of 0 or of 9..15 is illegal. The accepted word then sets out_err to 1 and makes out_vec equal to the accumulator vector. A legal shift sets out_err to 0.
- R7: out_valid is 1 in exactly the cycle after the cycle in which in_valid was 1 at a rising clock edge.
- R8: A synchronous active-high reset clears out_valid, out_err and out_vec to 0.
- R9: Lanes are independent. Different values in different lanes each produce their own R1 result in the same word.
- R10: While in_valid is 0, out_vec and out_err keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid strobe |
| acc_vec | input | VEC_W | Accumulator lanes |
| src_vec | input | VEC_W | Source lanes to be shifted |
| shamt | input | 4 | Immediate right-shift amount |
| out_valid | output | 1 | Registered result valid |
| out_vec | output | VEC_W | Registered per-lane sums |
| out_err | output | 1 | Registered illegal-shift flag |

## Verification
The lanes are filled with a rotation of the corner values -128, -1, 0 and 127, and this pattern is run through every legal shift. It separates correct rounding from plain truncation and from rounding with the wrong sign, and it exposes any intermediate that is only 8 bits wide. Random operands at every shift catch off-by-one errors in the shift or rounding-bit position. Accumulators near +127 and -128 show whether the final add wraps or saturates. Illegal shifts, idle cycles with changing inputs and a reset in the middle of a run show that the error path, the hold behaviour and the reset behave apart from the arithmetic.

// File: rtl/rsa_pkg.sv
`timescale 1ns/1ps
package rsa_pkg;
  localparam int LANE_W    = 8;
  localparam int SH_W      = 4;
  localparam int MAX_SHIFT = 8;
  typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/rsa_shamt_check.sv
`timescale 1ns/1ps
module rsa_shamt_check #(
  parameter int SH_W      = 4,
  parameter int MAX_SHIFT = 8
) (
  input  logic [SH_W-1:0] shamt,
  output logic            legal
);
  localparam logic [SH_W-1:0] MAX_V = SH_W'(MAX_SHIFT);
  always_comb begin
    legal = (shamt != '0) && (shamt <= MAX_V);
  end
endmodule

// File: rtl/rsa_lane.sv
`timescale 1ns/1ps
module rsa_lane #(
  parameter int LANE_W = 8,
  parameter int SH_W   = 4
) (
  input  logic [LANE_W-1:0] acc,
  input  logic [LANE_W-1:0] src,
  input  logic [SH_W-1:0]   shamt,
  output logic [LANE_W-1:0] res
);
  localparam int EXT_W = LANE_W + 1;

  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] rnd;
  logic signed [EXT_W-1:0] biased;
  logic signed [EXT_W-1:0] shifted;

  always_comb begin
    ext = $signed({src[LANE_W-1], src});
    rnd = '0;
    if (shamt != '0) begin
      rnd = $signed(EXT_W'(1) << (shamt - SH_W'(1)));
    end
    biased  = ext + rnd;
    shifted = biased >>> shamt;
    res     = acc + shifted[LANE_W-1:0];
  end
endmodule

// File: rtl/rsa_out_reg.sv
`timescale 1ns/1ps
module rsa_out_reg #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             d_valid,
  input  logic [VEC_W-1:0] d_vec,
  input  logic             d_err,
  output logic             q_valid,
  output logic [VEC_W-1:0] q_vec,
  output logic             q_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_vec   <= '0;
      q_err   <= 1'b0;
    end else begin
      q_valid <= d_valid;
      if (d_valid) begin
        q_vec <= d_vec;
        q_err <= d_err;
      end
    end
  end
endmodule

// File: rtl/lane_rshift_acc.sv
`timescale 1ns/1ps
module lane_rshift_acc #(
  parameter int VEC_W = 128
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [VEC_W-1:0]         acc_vec,
  input  logic [VEC_W-1:0]         src_vec,
  input  logic [rsa_pkg::SH_W-1:0] shamt,
  output logic                     out_valid,
  output logic [VEC_W-1:0]         out_vec,
  output logic                     out_err
);
  import rsa_pkg::*;
  localparam int NLANES = VEC_W / LANE_W;

  logic             sh_legal;
  logic [VEC_W-1:0] lane_sum;
  logic [VEC_W-1:0] next_vec;

  rsa_shamt_check #(.SH_W(SH_W), .MAX_SHIFT(MAX_SHIFT)) u_shchk (
    .shamt (shamt),
    .legal (sh_legal)
  );

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    rsa_lane #(.LANE_W(LANE_W), .SH_W(SH_W)) u_lane (
      .acc   (acc_vec[k*LANE_W +: LANE_W]),
      .src   (src_vec[k*LANE_W +: LANE_W]),
      .shamt (shamt),
      .res   (lane_sum[k*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    next_vec = sh_legal ? lane_sum : acc_vec;
  end

  rsa_out_reg #(.VEC_W(VEC_W)) u_oreg (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d_vec   (next_vec),
    .d_err   (~sh_legal),
    .q_valid (out_valid),
    .q_vec   (out_vec),
    .q_err   (out_err)
  );
endmodule

// File: rtl/rsa_checker.sv
`timescale 1ns/1ps
module rsa_checker #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [VEC_W-1:0] acc_vec,
  input logic [VEC_W-1:0] src_vec,
  input logic [3:0]       shamt,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_vec,
  input logic             out_err
);
  localparam int NLANES = VEC_W / 8;

  logic             q_vld;
  logic [VEC_W-1:0] q_acc;
  logic [VEC_W-1:0] q_src;
  logic [3:0]       q_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld <= 1'b0;
      q_acc <= '0;
      q_src <= '0;
      q_sh  <= '0;
    end else begin
      q_vld <= in_valid;
      q_acc <= acc_vec;
      q_src <= src_vec;
      q_sh  <= shamt;
    end
  end

  function automatic logic [7:0] trunc_plus_bit(input logic [7:0] a, input logic [7:0] s,
                                                input logic [3:0] sh);
    logic [2:0] idx;
    logic [7:0] plain;
    idx   = 3'(sh - 4'd1);
    plain = 8'($signed(s) >>> sh);
    return a + plain + {7'd0, s[idx]};
  endfunction

  logic q_legal;
  assign q_legal = (q_sh >= 4'd1) && (q_sh <= 4'd8);

  // R7
  p_valid_lat_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_lat_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8
  p_reset_clr_r8: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_err && out_vec == '0));
  // R6
  p_err_illegal_r6: assert property (@(posedge clk) disable iff (rst)
    (q_vld && !q_legal) |-> (out_err && out_vec == q_acc));
  p_err_legal_r6: assert property (@(posedge clk) disable iff (rst)
    (q_vld && q_legal) |-> !out_err);
  // R10
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_vec) && $stable(out_err)));

  // R2 per lane
  for (genvar k = 0; k < NLANES; k++) begin : g_ln
    p_round_bit_r2: assert property (@(posedge clk) disable iff (rst)
      (q_vld && q_legal) |->
        (out_vec[8*k +: 8] == trunc_plus_bit(q_acc[8*k +: 8], q_src[8*k +: 8], q_sh)));
  end
endmodule

bind lane_rshift_acc rsa_checker #(.VEC_W(VEC_W)) u_rsa_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .acc_vec   (acc_vec),
  .src_vec   (src_vec),
  .shamt     (shamt),
  .out_valid (out_valid),
  .out_vec   (out_vec),
  .out_err   (out_err)
);

// File: tb/lane_rshift_acc_bench.sv
`timescale 1ns/1ps
module lane_rshift_acc_bench;
  localparam int VEC_W  = 128;
  localparam int NL     = VEC_W / 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [VEC_W-1:0] acc_vec = '0;
  logic [VEC_W-1:0] src_vec = '0;
  logic [3:0]       shamt = 4'd1;
  logic             out_valid;
  logic [VEC_W-1:0] out_vec;
  logic             out_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lane_rshift_acc #(.VEC_W(VEC_W)) u_lane_rshift_acc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .acc_vec(acc_vec), .src_vec(src_vec),
    .shamt(shamt), .out_valid(out_valid), .out_vec(out_vec), .out_err(out_err)
  );

  function automatic logic [7:0] model_lane(input logic [7:0] a, input logic [7:0] s, input int sh);
    int sv, t;
    sv = int'($signed(s));
    t  = (sv + (1 <<< (sh - 1))) >>> sh;
    return 8'(int'($signed(a)) + t);
  endfunction

  function automatic logic [VEC_W-1:0] model_vec(input logic [VEC_W-1:0] a,
                                                 input logic [VEC_W-1:0] s, input int sh);
    logic [VEC_W-1:0] r;
    for (int k = 0; k < NL; k++) r[8*k +: 8] = model_lane(a[8*k +: 8], s[8*k +: 8], sh);
    return r;
  endfunction

  task automatic chk(input string req, input logic [VEC_W-1:0] got, input logic [VEC_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] s, input logic [3:0] sh);
    @(negedge clk);
    acc_vec = a; src_vec = s; shamt = sh; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_legal(input string req, input logic [VEC_W-1:0] a,
                           input logic [VEC_W-1:0] s, input int sh);
    drive(a, s, 4'(sh));
    chk(req, out_vec, model_vec(a, s, sh));
    chk({req, " valid/err"}, {126'd0, out_valid, out_err}, {126'd0, 1'b1, 1'b0});
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset state", {out_vec}, '0);
    chk("R8 reset flags", {126'd0, out_valid, out_err}, '0);
    rst = 1'b0;
  endtask

  task automatic t_corners;
    logic [7:0] cv [4] = '{8'h80, 8'hFF, 8'h00, 8'h7F};
    logic [VEC_W-1:0] a, s;
    for (int k = 0; k < NL; k++) begin
      s[8*k +: 8] = cv[k % 4];
      a[8*k +: 8] = cv[(k / 4) % 4];
    end
    for (int sh = 1; sh <= 8; sh++) run_legal("R1 corners", a, s, sh);
  endtask

  task automatic t_random;
    logic [VEC_W-1:0] a, s;
    for (int sh = 1; sh <= 8; sh++) begin
      for (int n = 0; n < 6; n++) begin
        for (int w = 0; w < VEC_W / 32; w++) begin
          a[32*w +: 32] = $urandom;
          s[32*w +: 32] = $urandom;
        end
        run_legal("R2 random", a, s, sh);
      end
    end
  endtask

  task automatic t_no_overflow;
    drive('0, {NL{8'h7F}}, 4'd1);
    chk("R3 127>>1", out_vec, {NL{8'h40}});
    drive('0, {NL{8'h7F}}, 4'd7);
    chk("R3 127>>7", out_vec, {NL{8'h01}});
  endtask

  task automatic t_shift8;
    logic [VEC_W-1:0] s, a;
    for (int k = 0; k < NL; k++) begin
      s[8*k +: 8] = 8'(8'h80 + 8'(k * 17));
      a[8*k +: 8] = 8'(k * 5 + 3);
    end
    drive(a, s, 4'd8);
    chk("R4 shift 8 leaves acc", out_vec, a);
    drive('0, {NL{8'h80}}, 4'd8);
    chk("R4 -128 by 8", out_vec, '0);
    drive('0, {NL{8'hFF}}, 4'd8);
    chk("R4 -1 by 8", out_vec, '0);
  endtask

  task automatic t_wrap;
    drive({NL{8'h7F}}, {NL{8'h02}}, 4'd1);
    chk("R5 wrap up", out_vec, {NL{8'h80}});
    drive({NL{8'h80}}, {NL{8'hFC}}, 4'd2);
    chk("R5 wrap down", out_vec, {NL{8'h7F}});
  endtask

  task automatic t_illegal;
    logic [VEC_W-1:0] a, s;
    int bad [4] = '{0, 9, 12, 15};
    for (int i = 0; i < 4; i++) begin
      for (int w = 0; w < VEC_W / 32; w++) begin
        a[32*w +: 32] = $urandom;
        s[32*w +: 32] = $urandom;
      end
      drive(a, s, 4'(bad[i]));
      chk("R6 illegal passes acc", out_vec, a);
      chk("R6 illegal err", {127'd0, out_err}, {127'd0, 1'b1});
    end
    run_legal("R6 err clears", {NL{8'h11}}, {NL{8'h22}}, 3);
  endtask

  task automatic t_latency;
    @(negedge clk);
    acc_vec = {NL{8'h05}}; src_vec = {NL{8'h10}}; shamt = 4'd4; in_valid = 1'b1;
    chk("R7 not yet valid", {127'd0, out_valid}, '0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 valid after one clock", {127'd0, out_valid}, {127'd0, 1'b1});
    chk("R7 data", out_vec, {NL{8'h06}});
    @(posedge clk);
    @(negedge clk);
    chk("R7 valid drops", {127'd0, out_valid}, '0);
  endtask

  task automatic t_hold;
    logic [VEC_W-1:0] keep;
    drive({NL{8'h30}}, {NL{8'h08}}, 4'd3);
    keep = out_vec;
    acc_vec = '1; src_vec = {NL{8'h55}}; shamt = 4'd0;
    repeat (3) @(negedge clk);
    chk("R10 hold vec", out_vec, keep);
    chk("R10 hold err", {126'd0, out_valid, out_err}, '0);
  endtask

  task automatic t_lanes;
    logic [VEC_W-1:0] a, s;
    for (int k = 0; k < NL; k++) begin
      a[8*k +: 8] = 8'(k * 13 - 100);
      s[8*k +: 8] = 8'(k * 29 + 7);
    end
    run_legal("R9 distinct lanes", a, s, 3);
  endtask

  task automatic t_mid_reset;
    drive({NL{8'h44}}, {NL{8'h01}}, 4'd0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R8 mid-run reset vec", out_vec, '0);
    chk("R8 mid-run reset flags", {126'd0, out_valid, out_err}, '0);
  endtask

  initial begin
    t_reset();
    t_corners();
    t_random();
    t_no_overflow();
    t_shift8();
    t_wrap();
    t_illegal();
    t_latency();
    t_hold();
    t_lanes();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule